// File: doc/BRIEF.md
# Page ECC Error Report Aggregator

This block sits beside a page-read datapath that decodes a page as a series of error-corrected packets. Each packet's decode result arrives as a one-cycle pulse. The pulse carries a pass flag, a 6-bit count of corrected bits and a marker for the last packet. The block folds these pulses into one 16-bit page report. It also flags a page that an erased-page detector has reported as blank.

The first packet has its own report byte, because it protects four extra metadata bytes and its result is kept separately. Every later packet is merged into the second byte. That byte keeps the worst count seen over those packets and the AND of their pass flags. When the last packet arrives, the block marks the page result valid and gives a summary. The summary is either the page's maximum corrected-bit count or an uncorrectable flag. A blank page always reports zero bitflips.

The report and a status word can also be read through a small read-only address port.

Top module: `page_ecc_report`

## Requirements
- R1: Report bits 5:0 hold the first packet's count and bit 7 its pass flag; bit 6 reads 0; before the first packet of a page the byte reads 0x80.
- R2: Report bits 13:8 hold the largest count over all packets after the first and bit 15 the AND of their pass flags; bit 14 reads 0.
- R3: On a page with a single packet, report bits 15:8 read 0x80 (pass, count zero).
- R4: A page_start pulse clears both report bytes to 0x80, clears page_valid and page_empty, and opens the page; a packet or erased pulse in the same cycle as page_start is dropped.
- R5: On the clock edge that accepts a packet with pkt_last set, the page closes. From the next cycle page_valid is 1 until the next page_start, and page_done is 1 for exactly that one cycle.
- R6: Packet pulses and erased_in pulses have no effect while no page is open, that is after reset and before the first page_start, or after the last packet.
- R7: An erased_in pulse while a page is open sets page_empty; a valid empty page gives page_flips 0 and page_uncorr 0 whatever the report holds.
- R8: For a valid non-empty page with both pass flags set, page_flips is the larger of the two report counts and page_uncorr is 0. If either flag is clear, page_uncorr is 1 and page_flips is 0. While page_valid is 0, both outputs are 0.
- R9: rd_addr 0 returns the report in rd_data bits 15:0; rd_addr 1 returns page_empty in bit 16 and page_valid in bit 0; every other bit and address reads 0.
- R10: After reset the report is 0x8080 and page_valid, page_empty, page_done, page_flips, page_uncorr and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Pulse that opens a new page read |
| pkt_valid | input | 1 | Packet decode result present |
| pkt_ok | input | 1 | Packet decoded successfully |
| pkt_cnt | input | 6 | Corrected bit count of the packet |
| pkt_last | input | 1 | Packet is the last of the page |
| erased_in | input | 1 | Erased-page detect pulse |
| rd_addr | input | ADDR_W (2) | Register read address |
| rd_data | output | DATA_W (32) | Register read data |
| report | output | 16 | Page error report word |
| page_valid | output | 1 | Page result complete |
| page_empty | output | 1 | Page detected as erased |
| page_done | output | 1 | One-cycle pulse at page completion |
| page_flips | output | 6 | Page maximum corrected bit count |
| page_uncorr | output | 1 | Page uncorrectable |

## Verification
The bench builds the block with its default parameters: a 32-bit read port and a 2-bit address. This reaches both defined addresses and two unused ones that must read zero. Pages of one to eight packets are generated with random pass flags and counts, and the all-ones count 63 is weighted heavily. This exercises the maximum on both bytes, single-packet pages, failures in either byte, erased pages, stray pulses outside a page, and a page_start that collides with a packet.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;

  localparam int CNT_W  = 6;
  localparam int BYTE_W = 8;
  localparam int RPT_W  = 2 * BYTE_W;
  localparam int OK_BIT = BYTE_W - 1;

  typedef struct packed {
    logic             ok;
    logic [CNT_W-1:0] cnt;
  } slot_t;

  localparam slot_t SLOT_CLEAR = '{ok: 1'b1, cnt: '0};

  function automatic logic [CNT_W-1:0] cnt_max(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [BYTE_W-1:0] slot_byte(input slot_t s);
    logic [BYTE_W-1:0] b;
    b             = '0;
    b[OK_BIT]     = s.ok;
    b[CNT_W-1:0]  = s.cnt;
    return b;
  endfunction

  function automatic logic [RPT_W-1:0] pack_report(input slot_t s0, input slot_t sn);
    return {slot_byte(sn), slot_byte(s0)};
  endfunction

endpackage

// File: rtl/ecc_page_seq.sv
module ecc_page_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic page_start,
  input  logic pkt_valid,
  input  logic pkt_last,
  input  logic erased_in,
  output logic clr,
  output logic take_first,
  output logic take_rest,
  output logic page_valid,
  output logic page_empty,
  output logic page_done
);

  logic busy;
  logic first_seen;
  logic accept;

  assign clr        = page_start;
  assign accept     = pkt_valid & busy & ~page_start;
  assign take_first = accept & ~first_seen;
  assign take_rest  = accept & first_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      first_seen <= 1'b0;
      page_valid <= 1'b0;
      page_empty <= 1'b0;
      page_done  <= 1'b0;
    end else begin
      page_done <= accept & pkt_last;
      if (page_start) begin
        busy       <= 1'b1;
        first_seen <= 1'b0;
        page_valid <= 1'b0;
        page_empty <= 1'b0;
      end else begin
        if (accept) first_seen <= 1'b1;
        if (accept && pkt_last) begin
          busy       <= 1'b0;
          page_valid <= 1'b1;
        end
        if (busy && erased_in) page_empty <= 1'b1;
      end
    end
  end

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> (!page_valid && !page_empty));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done);

  // R5
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> page_valid);

  // R6
  idle_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !page_start) |=> (page_empty == $past(page_empty)));

  // R1
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> !take_first);

endmodule

// File: rtl/ecc_slot_acc.sv
module ecc_slot_acc
  import ecc_rpt_pkg::*;
#(
  parameter bit IS_FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             pkt_ok,
  input  logic [CNT_W-1:0] pkt_cnt,
  output slot_t            q
);

  generate
    if (IS_FIRST) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= SLOT_CLEAR;
        else if (clr)    q <= SLOT_CLEAR;
        else if (take)   q <= '{ok: pkt_ok, cnt: pkt_cnt};
      end

      // R1
      first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (q.ok == $past(pkt_ok) && q.cnt == $past(pkt_cnt)));
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= SLOT_CLEAR;
        end else if (clr) begin
          q <= SLOT_CLEAR;
        end else if (take) begin
          q.ok  <= q.ok & pkt_ok;
          q.cnt <= cnt_max(q.cnt, pkt_cnt);
        end
      end

      // R2
      rest_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (q.cnt >= $past(q.cnt)));

      // R2
      rest_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (q.cnt >= $past(pkt_cnt)));

      // R2
      rest_okfall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ok) |-> $past(take && !pkt_ok));
    end
  endgenerate

endmodule

// File: rtl/ecc_page_resolve.sv
module ecc_page_resolve
  import ecc_rpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_valid,
  input  logic             page_empty,
  input  slot_t            s0,
  input  slot_t            sn,
  output logic [CNT_W-1:0] flips,
  output logic             uncorr
);

  logic both_ok;
  logic judged;

  assign both_ok = s0.ok & sn.ok;
  assign judged  = page_valid & ~page_empty;

  always_comb begin
    flips  = '0;
    uncorr = 1'b0;
    if (judged) begin
      if (both_ok) flips  = cnt_max(s0.cnt, sn.cnt);
      else         uncorr = 1'b1;
    end
  end

  // R8
  uncorr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> (flips == '0));

  // R7
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_empty |-> (!uncorr && flips == '0));

  // R8
  flips_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_valid && !page_empty && !uncorr) |-> (flips >= s0.cnt && flips >= sn.cnt));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_valid |-> (!uncorr && flips == '0));

endmodule

// File: rtl/page_ecc_report.sv
module page_ecc_report
  import ecc_rpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_start,
  input  logic              pkt_valid,
  input  logic              pkt_ok,
  input  logic [CNT_W-1:0]  pkt_cnt,
  input  logic              pkt_last,
  input  logic              erased_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [RPT_W-1:0]  report,
  output logic              page_valid,
  output logic              page_empty,
  output logic              page_done,
  output logic [CNT_W-1:0]  page_flips,
  output logic              page_uncorr
);

  localparam int NSLOT     = 2;
  localparam int EMPTY_BIT = 16;
  localparam int VALID_BIT = 0;
  localparam logic [ADDR_W-1:0] A_REPORT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);

  logic  clr;
  logic  take_first;
  logic  take_rest;
  logic  take_v [NSLOT];
  slot_t slot_q [NSLOT];

  ecc_page_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_start (page_start),
    .pkt_valid  (pkt_valid),
    .pkt_last   (pkt_last),
    .erased_in  (erased_in),
    .clr        (clr),
    .take_first (take_first),
    .take_rest  (take_rest),
    .page_valid (page_valid),
    .page_empty (page_empty),
    .page_done  (page_done)
  );

  assign take_v[0] = take_first;
  assign take_v[1] = take_rest;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    ecc_slot_acc #(.IS_FIRST(i == 0)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .take    (take_v[i]),
      .pkt_ok  (pkt_ok),
      .pkt_cnt (pkt_cnt),
      .q       (slot_q[i])
    );
  end

  assign report = pack_report(slot_q[0], slot_q[1]);

  ecc_page_resolve u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_valid (page_valid),
    .page_empty (page_empty),
    .s0         (slot_q[0]),
    .sn         (slot_q[1]),
    .flips      (page_flips),
    .uncorr     (page_uncorr)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_REPORT: rd_data[RPT_W-1:0] = report;
      A_STATUS: begin
        rd_data[EMPTY_BIT] = page_empty;
        rd_data[VALID_BIT] = page_valid;
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: tb/page_ecc_report_bench.sv
`timescale 1ns/1ps
module page_ecc_report_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_start = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ok = 1'b0;
  logic [5:0]  pkt_cnt = '0;
  logic        pkt_last = 1'b0;
  logic        erased_in = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] report;
  logic        page_valid, page_empty, page_done, page_uncorr;
  logic [5:0]  page_flips;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  page_ecc_report u_page_ecc_report (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .pkt_valid(pkt_valid),
    .pkt_ok(pkt_ok), .pkt_cnt(pkt_cnt), .pkt_last(pkt_last), .erased_in(erased_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .report(report), .page_valid(page_valid),
    .page_empty(page_empty), .page_done(page_done), .page_flips(page_flips),
    .page_uncorr(page_uncorr)
  );

  // Behavioural reference model
  bit m_busy = 0, m_first = 0, m_valid = 0, m_empty = 0, m_done = 0;
  bit m_ok0 = 1;
  int m_cnt0 = 0;
  int rest_cnt [$];
  bit rest_ok  [$];

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_busy = 0; m_first = 0; m_valid = 0; m_empty = 0; m_done = 0;
      m_ok0 = 1; m_cnt0 = 0; rest_cnt.delete(); rest_ok.delete();
    end else begin
      acc = pkt_valid && m_busy && !page_start;
      m_done = acc && pkt_last;
      if (page_start) begin
        m_busy = 1; m_first = 0; m_valid = 0; m_empty = 0;
        m_ok0 = 1; m_cnt0 = 0; rest_cnt.delete(); rest_ok.delete();
      end else begin
        if (m_busy && erased_in) m_empty = 1;
        if (acc) begin
          if (!m_first) begin
            m_ok0 = pkt_ok; m_cnt0 = pkt_cnt; m_first = 1;
          end else begin
            rest_cnt.push_back(pkt_cnt); rest_ok.push_back(pkt_ok);
          end
          if (pkt_last) begin m_busy = 0; m_valid = 1; end
        end
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rest_max();
    int m = 0;
    foreach (rest_cnt[i]) if (rest_cnt[i] > m) m = rest_cnt[i];
    return m;
  endfunction

  function automatic bit rest_all_ok();
    bit r = 1;
    foreach (rest_ok[i]) r &= rest_ok[i];
    return r;
  endfunction

  task automatic compare();
    int b0, b1, fl, un, mx;
    longint rd;
    bit okn;
    okn = rest_all_ok();
    mx  = rest_max();
    b0  = (m_ok0 ? 'h80 : 0) + m_cnt0;
    b1  = (okn ? 'h80 : 0) + mx;
    fl = 0; un = 0;
    if (m_valid && !m_empty) begin
      if (m_ok0 && okn) fl = (m_cnt0 > mx) ? m_cnt0 : mx;
      else un = 1;
    end
    rd = 0;
    if (rd_addr == 0) rd = b1 * 256 + b0;
    else if (rd_addr == 1) rd = (m_empty ? 'h10000 : 0) + (m_valid ? 1 : 0);
    chk("R1 report byte0", report[7:0], b0);
    chk("R2 report byte1", report[15:8], b1);
    chk("R5 page_valid", page_valid, m_valid);
    chk("R5 page_done", page_done, m_done);
    chk("R7 page_empty", page_empty, m_empty);
    chk("R8 page_flips", page_flips, fl);
    chk("R8 page_uncorr", page_uncorr, un);
    chk("R9 rd_data", rd_data, rd);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input bit ps, input bit v, input bit ok, input int cnt,
                       input bit last, input bit er);
    page_start = ps; pkt_valid = v; pkt_ok = ok; pkt_cnt = 6'(cnt);
    pkt_last = last; erased_in = er; rd_addr = 2'($urandom % 4);
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic rand_page();
    int n;
    bit collide;
    n = 1 + $urandom % 8;
    collide = ($urandom % 6) == 0;
    drive(1, collide, $urandom % 2, $urandom % 64, $urandom % 2, collide);
    for (int k = 0; k < n; k++) begin
      while (($urandom % 3) == 0) drive(0, 0, 0, 0, 0, ($urandom % 12) == 0);
      drive(0, 1, ($urandom % 8) != 0, (($urandom % 4) == 0) ? 63 : $urandom % 64,
            k == n - 1, ($urandom % 12) == 0);
    end
    if (($urandom % 4) == 0) begin
      drive(0, 1, 0, 63, $urandom % 2, 1);   // R6 stray after close
      drive(0, 1, 1, 17, 1, 0);
    end
    idle($urandom % 3);
  endtask

  initial begin
    // R10 reset state
    tick(); tick();
    @(negedge clk); rst_n = 1'b1;
    rd_addr = 2'd1;
    tick();
    chk("R10 reset report", report, 16'h8080);
    chk("R10 reset status", rd_data, 0);
    chk("R10 reset flags", {page_valid, page_empty, page_done, page_uncorr, page_flips}, 0);

    // R6 stray pulses before any page
    drive(0, 1, 0, 45, 1, 1);
    drive(0, 1, 1, 12, 0, 1);
    chk("R6 no page open report", report, 16'h8080);
    chk("R6 no page open flags", {page_valid, page_empty}, 0);

    // R3 single-packet page
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 1, 1, 5, 1, 0);
    chk("R3 single packet byte1", report[15:8], 8'h80);
    chk("R3 single packet byte0", report[7:0], 8'h85);
    chk("R8 single packet flips", page_flips, 5);

    // R4 collision: packet with page_start dropped
    drive(1, 1, 0, 33, 1, 1);
    chk("R4 collision dropped", report, 16'h8080);
    chk("R4 collision flags", {page_valid, page_empty}, 0);
    drive(0, 1, 1, 2, 0, 0);
    drive(0, 1, 1, 63, 0, 0);
    drive(0, 1, 0, 7, 1, 0);
    chk("R2 failing later packet", report, 16'h3f82);
    chk("R8 uncorrectable", {page_uncorr, page_flips}, 7'h40);

    // R7 erased page overrides failure
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 40, 0, 1);
    drive(0, 1, 0, 50, 1, 0);
    chk("R7 empty page clean", {page_empty, page_uncorr, page_flips}, 8'h80);

    for (int p = 0; p < 400; p++) rand_page();

    idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule